// File: doc/BRIEF.md
# Multi-Channel Buffered PWM Generator

This block drives several PWM outputs from one shared time base. A prescaler divides the clock and advances a single wrapping counter. Each channel sets its output active when the count reaches its turn-on value and inactive when the count reaches its turn-off value. A host writes all settings one byte at a time over a simple strobe interface, and marks the end of each bus transaction with a pulse.

Channel settings first land in shadow storage. In the default mode they move to the working compare values only when the counter wraps, so a period that has started always finishes with the settings it began with. A second mode collects all four bytes of a channel and applies them together at the end of the transaction that completes the set. This means a partial update can never reach the output.

A global sleep control stops the time base and forces every output inactive. The prescaler can only be changed while the block is asleep. If channels were running when the block went to sleep, waking up leaves them parked until the host requests a restart. After a restart request the oscillator settles for a fixed number of clocks, and then counting resumes. An invert control decides whether the inactive level is low or high.

Top module: `pwm_multi_top`

## Requirements
- R1: After reset the block is asleep, every `pwm_out` bit is 0 and `restart_pending` is 0.
- R2: While running, the counter starts at 0, advances once every PRESCALE+1 clocks and wraps from 2^CNT_W-1 to 0. A channel output turns active when the count reaches its ON value and inactive when it reaches its OFF value. If ON equals OFF, OFF wins and the output is always inactive. If ON is greater than OFF, the active phase spans the wrap.
- R3: Register map, byte address: 0x00 mode (bit0 sleep, bit1 invert, bit2 acknowledge-update mode, bit3 restart request, write-one). 0x01 prescale. Channel n uses 0x08+4n+k, with k=0 ON[7:0], k=1 ON[11:8] in bits 3:0 and channel enable in bit 4, k=2 OFF[7:0], k=3 OFF[11:8].
- R4: In the default update mode, a channel byte written while running takes effect at the next counter wrap. The period in progress completes with the old values.
- R5: In acknowledge-update mode, each channel tracks which of its four bytes have been written. The new values are applied only on an `xact_end` pulse that arrives once all four bytes are marked, and that pulse clears the tracking. A transaction that writes fewer bytes changes nothing at the output.
- R6: A channel whose applied enable bit is 0 drives the inactive level constantly.
- R7: While asleep, every output is at the inactive level.
- R8: The inactive level is 0 when the invert bit is 0, and 1 when it is 1. An active output takes the opposite level. A change to the invert bit shows on the outputs one clock after the write.
- R9: A prescale write takes effect only while the block is asleep. A write at any other time is ignored.
- R10: If any channel was enabled when sleep began, clearing sleep parks the block with all outputs inactive and `restart_pending` set to 1. It stays parked until a mode write with bit3 set, which clears `restart_pending` and resumes the saved channel settings.
- R11: After a wake without saved channels, or after a restart request, the block waits SETTLE_CYC clocks with all outputs inactive before the counter starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register byte write strobe |
| wr_addr | input | ADDR_W | Register byte address |
| wr_data | input | 8 | Register byte data |
| xact_end | input | 1 | End-of-transaction pulse from the bus front end |
| pwm_out | output | NCH | Channel outputs after polarity |
| restart_pending | output | 1 | Block is parked after wake and waits for a restart request |

## Verification
The assertions check on every cycle that the outputs sit at the inactive level while the block is asleep, parked or settling, and whenever a channel's applied enable is clear. They also check that the prescale value never moves outside sleep and that each prescaler tick advances the counter by exactly one. The bench scenarios are needed for the timing that depends on history: deferring a running update to the next wrap, rejecting a partial transaction in acknowledge-update mode, and the wrap-spanning active phase. The scenarios also cover the park-and-restart sequence together with its settle delay and the new prescale value that becomes visible after it.

// File: rtl/pwm_multi_pkg.sv
package pwm_multi_pkg;

    typedef enum logic [1:0] {
        ST_SLEEP  = 2'd0,
        ST_HALT   = 2'd1,
        ST_SETTLE = 2'd2,
        ST_RUN    = 2'd3
    } run_state_e;

    localparam int MODE_ADDR  = 0;
    localparam int PRE_ADDR   = 1;
    localparam int CH_BASE    = 8;

    localparam int MB_SLEEP   = 0;
    localparam int MB_INV     = 1;
    localparam int MB_ACK     = 2;
    localparam int MB_RESTART = 3;

    localparam int EN_BIT     = 4;

endpackage

// File: rtl/pwm_multi_ctrl.sv
module pwm_multi_ctrl
    import pwm_multi_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int PRE_W      = 8,
    parameter int SETTLE_CYC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              any_en,
    output run_state_e        state,
    output logic              inv,
    output logic              ack_mode,
    output logic [PRE_W-1:0]  prescale,
    output logic              restart_pending
);

    localparam int SET_W = (SETTLE_CYC > 2) ? $clog2(SETTLE_CYC) : 1;

    typedef struct packed {
        run_state_e       st;
        logic             sleep;
        logic             inv;
        logic             ack;
        logic             restart;
        logic             was_run;
        logic [SET_W-1:0] settle;
        logic [PRE_W-1:0] pre;
    } ctrl_t;

    ctrl_t q, d;

    logic unused_data;
    assign unused_data = ^wr_data[7:4];

    always_comb begin
        d = q;
        d.restart = 1'b0;

        if (wr_en && wr_addr == ADDR_W'(MODE_ADDR)) begin
            d.sleep   = wr_data[MB_SLEEP];
            d.inv     = wr_data[MB_INV];
            d.ack     = wr_data[MB_ACK];
            d.restart = wr_data[MB_RESTART];
        end
        if (wr_en && wr_addr == ADDR_W'(PRE_ADDR) && q.st == ST_SLEEP) begin
            d.pre = wr_data[PRE_W-1:0];
        end

        case (q.st)
            ST_SLEEP: begin
                if (!q.sleep) begin
                    if (q.was_run) begin
                        d.st = ST_HALT;
                    end else begin
                        d.st     = ST_SETTLE;
                        d.settle = '0;
                    end
                end
            end
            ST_HALT: begin
                if (q.sleep) begin
                    d.st = ST_SLEEP;
                end else if (q.restart) begin
                    d.st      = ST_SETTLE;
                    d.settle  = '0;
                    d.was_run = 1'b0;
                end
            end
            ST_SETTLE: begin
                if (q.sleep) begin
                    d.st = ST_SLEEP;
                end else if (q.settle == SET_W'(SETTLE_CYC - 1)) begin
                    d.st = ST_RUN;
                end else begin
                    d.settle = q.settle + 1'b1;
                end
            end
            default: begin
                if (q.sleep) begin
                    d.st      = ST_SLEEP;
                    d.was_run = any_en;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.st      <= ST_SLEEP;
            q.sleep   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign state           = q.st;
    assign inv             = q.inv;
    assign ack_mode        = q.ack;
    assign prescale        = q.pre;
    assign restart_pending = (q.st == ST_HALT);

endmodule

// File: rtl/pwm_multi_timebase.sv
module pwm_multi_timebase #(
    parameter int CNT_W = 12,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] prescale,
    output logic             tick,
    output logic             evt,
    output logic [CNT_W-1:0] cnt_ev,
    output logic [CNT_W-1:0] cnt
);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
        logic             run_prev;
    } tb_t;

    tb_t  q, d;
    logic start;

    always_comb begin
        d          = q;
        d.run_prev = run;
        start      = run && !q.run_prev;
        tick       = run && q.run_prev && (q.pre == prescale);

        if (!run || start) begin
            d.pre = '0;
            d.cnt = '0;
        end else if (tick) begin
            d.pre = '0;
            d.cnt = q.cnt + 1'b1;
        end else begin
            d.pre = q.pre + 1'b1;
        end

        evt    = start || tick;
        cnt_ev = tick ? (q.cnt + 1'b1) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cnt = q.cnt;

endmodule

// File: rtl/pwm_multi_chan.sv
module pwm_multi_chan
    import pwm_multi_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [7:0]       wr_data,
    input  logic             xact_end,
    input  logic             ack_mode,
    input  logic             run,
    input  logic             evt,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cnt_ev,
    output logic             level,
    output logic             en
);

    localparam int HI_W = CNT_W - 8;

    typedef struct packed {
        logic [CNT_W-1:0] on_s;
        logic [CNT_W-1:0] off_s;
        logic             en_s;
        logic [CNT_W-1:0] on_a;
        logic [CNT_W-1:0] off_a;
        logic             en_a;
        logic [3:0]       trk;
        logic             lvl;
    } ch_t;

    ch_t  q, d;
    logic take;

    logic unused_data;
    assign unused_data = ^wr_data[7:5];

    always_comb begin
        d    = q;
        take = 1'b0;

        if (wr_en) begin
            case (wr_sel)
                2'd0: d.on_s[7:0] = wr_data;
                2'd1: begin
                    d.on_s[CNT_W-1:8] = wr_data[HI_W-1:0];
                    d.en_s            = wr_data[EN_BIT];
                end
                2'd2: d.off_s[7:0] = wr_data;
                default: d.off_s[CNT_W-1:8] = wr_data[HI_W-1:0];
            endcase
            d.trk[wr_sel] = 1'b1;
        end

        if (ack_mode) begin
            if (xact_end && (&d.trk)) begin
                take  = 1'b1;
                d.trk = '0;
            end
        end else begin
            d.trk = '0;
            take  = !run || wrap;
        end

        if (take) begin
            d.on_a  = d.on_s;
            d.off_a = d.off_s;
            d.en_a  = d.en_s;
        end

        if (!run) begin
            d.lvl = 1'b0;
        end else if (evt) begin
            if (cnt_ev == d.off_a) begin
                d.lvl = 1'b0;
            end else if (cnt_ev == d.on_a) begin
                d.lvl = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign level = q.lvl;
    assign en    = q.en_a;

endmodule

// File: rtl/pwm_multi_top.sv
module pwm_multi_top
    import pwm_multi_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int CNT_W      = 12,
    parameter int PRE_W      = 8,
    parameter int ADDR_W     = 8,
    parameter int SETTLE_CYC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              xact_end,
    output logic [NCH-1:0]    pwm_out,
    output logic              restart_pending
);

    localparam int SLOT_W = ADDR_W - 2;
    localparam int SLOT0  = CH_BASE / 4;

    run_state_e       st;
    logic             inv;
    logic             ack_mode;
    logic [PRE_W-1:0] prescale;
    logic             run;
    logic             tick;
    logic             evt;
    logic             wrap;
    logic [CNT_W-1:0] cnt_ev;
    logic [CNT_W-1:0] cnt;
    logic [NCH-1:0]   lvl;
    logic [NCH-1:0]   en;

    pwm_multi_ctrl #(
        .ADDR_W    (ADDR_W),
        .PRE_W     (PRE_W),
        .SETTLE_CYC(SETTLE_CYC)
    ) i_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .any_en         (|en),
        .state          (st),
        .inv            (inv),
        .ack_mode       (ack_mode),
        .prescale       (prescale),
        .restart_pending(restart_pending)
    );

    assign run = (st == ST_RUN);

    pwm_multi_timebase #(
        .CNT_W(CNT_W),
        .PRE_W(PRE_W)
    ) i_tbase (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .prescale(prescale),
        .tick    (tick),
        .evt     (evt),
        .cnt_ev  (cnt_ev),
        .cnt     (cnt)
    );

    assign wrap = evt && (cnt_ev == '0);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic ch_we;
        assign ch_we = wr_en && (wr_addr[ADDR_W-1:2] == SLOT_W'(SLOT0 + i));

        pwm_multi_chan #(
            .CNT_W(CNT_W)
        ) i_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (ch_we),
            .wr_sel  (wr_addr[1:0]),
            .wr_data (wr_data),
            .xact_end(xact_end),
            .ack_mode(ack_mode),
            .run     (run),
            .evt     (evt),
            .wrap    (wrap),
            .cnt_ev  (cnt_ev),
            .level   (lvl[i]),
            .en      (en[i])
        );

        assign pwm_out[i] = inv ^ (lvl[i] & en[i] & run);
    end

endmodule

// File: rtl/pwm_multi_chk.sv
module pwm_multi_chk
    import pwm_multi_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int CNT_W = 12,
    parameter int PRE_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input run_state_e       st,
    input logic             inv,
    input logic [PRE_W-1:0] prescale,
    input logic [NCH-1:0]   pwm_out,
    input logic [NCH-1:0]   en,
    input logic             tick,
    input logic [CNT_W-1:0] cnt
);

    // R7: asleep means every output sits at the inactive level
    a_r7_sleep_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SLEEP) |-> (pwm_out == {NCH{inv}}));

    // R10: parked after wake, outputs inactive
    a_r10_halt_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HALT) |-> (pwm_out == {NCH{inv}}));

    // R11: settle window keeps outputs inactive
    a_r11_settle_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SETTLE) |-> (pwm_out == {NCH{inv}}));

    // R9: prescale cannot move unless asleep
    a_r9_prescale_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_SLEEP) |=> $stable(prescale));

    // R2: each prescaler tick advances the shared count by one
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    for (genvar i = 0; i < NCH; i++) begin : g_dis
        // R6: disabled channel holds the inactive level
        a_r6_disabled_inactive: assert property (@(posedge clk) disable iff (!rst_n)
            !en[i] |-> (pwm_out[i] == inv));
    end

endmodule

bind pwm_multi_top pwm_multi_chk #(
    .NCH  (NCH),
    .CNT_W(CNT_W),
    .PRE_W(PRE_W)
) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .st      (st),
    .inv     (inv),
    .prescale(prescale),
    .pwm_out (pwm_out),
    .en      (en),
    .tick    (tick),
    .cnt     (cnt)
);

// File: tb/test_pwm_multi_top.sv
module test_pwm_multi_top;

    localparam int NCH = 4;
    localparam int S   = 32;
    localparam int PER = 8192;   // 4096 counts at prescale 1

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [7:0]     wr_addr = '0;
    logic [7:0]     wr_data = '0;
    logic           xact_end = 1'b0;
    logic [NCH-1:0] pwm_out;
    logic           restart_pending;

    pwm_multi_top i_pwm_multi_top (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .xact_end       (xact_end),
        .pwm_out        (pwm_out),
        .restart_pending(restart_pending)
    );

    always #2 clk = ~clk;

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int unsigned    at;
        int             kind;   // 0 one output bit, 1 whole vector, 2 restart flag
        int             idx;
        logic [NCH-1:0] exp;
        string          tag;
    } exp_t;

    exp_t sb[$];
    int   n_chk  = 0;
    int   n_fail = 0;

    task automatic push(int unsigned at, int kind, int idx, logic [NCH-1:0] v, string tag);
        exp_t e;
        e.at = at; e.kind = kind; e.idx = idx; e.exp = v; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic exp_bit(int unsigned at, int idx, logic v, string tag);
        push(at, 0, idx, {{(NCH-1){1'b0}}, v}, tag);
    endtask

    task automatic exp_vec(int unsigned at, logic [NCH-1:0] v, string tag);
        push(at, 1, 0, v, tag);
    endtask

    task automatic exp_rp(int unsigned at, logic v, string tag);
        push(at, 2, 0, {{(NCH-1){1'b0}}, v}, tag);
    endtask

    // monitor: compares scoreboard items at their cycle
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t           e;
            logic [NCH-1:0] act;
            e = sb.pop_front();
            n_chk++;
            if (e.at < cyc) begin
                n_fail++;
                $display("FAIL %s: check for cycle %0d missed, actual cycle %0d expected %0d",
                         e.tag, e.at, cyc, e.at);
            end else begin
                case (e.kind)
                    0:       act = {{(NCH-1){1'b0}}, pwm_out[e.idx]};
                    1:       act = pwm_out;
                    default: act = {{(NCH-1){1'b0}}, restart_pending};
                endcase
                if (act !== e.exp) begin
                    n_fail++;
                    $display("FAIL %s: cycle %0d actual %b expected %b", e.tag, cyc, act, e.exp);
                end
            end
        end
    end

    task automatic wr(logic [7:0] a, logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_ch(int ch, int sel, logic [7:0] v);
        wr(8'(8 + 4 * ch + sel), v);
    endtask

    task automatic xact();
        @(negedge clk);
        xact_end = 1'b1;
        @(negedge clk);
        xact_end = 1'b0;
    endtask

    task automatic wait_to(int unsigned n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin : watchdog
        while (cyc < 150000) @(negedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual cycle %0d expected completion earlier", cyc);
        finish_run();
    end

    initial begin : driver
        int unsigned w, t0, t1, t2, t3, t4, wi, wn, ws, ww, wr_c;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        exp_vec(cyc + 1, '0, "R1 outputs");
        exp_rp(cyc + 1, 1'b0, "R1 restart flag");

        wr(8'h01, 8'd1);                                          // R9 accepted asleep
        wr_ch(0, 0, 8'd10);  wr_ch(0, 1, 8'h10); wr_ch(0, 2, 8'd50); wr_ch(0, 3, 8'h00);
        wr_ch(1, 0, 8'd100); wr_ch(1, 1, 8'h10); wr_ch(1, 2, 8'd20); wr_ch(1, 3, 8'h00);
        wr_ch(2, 0, 8'd30);  wr_ch(2, 1, 8'h10); wr_ch(2, 2, 8'd30); wr_ch(2, 3, 8'h00);
        wr_ch(3, 0, 8'd5);   wr_ch(3, 1, 8'h00); wr_ch(3, 2, 8'd60); wr_ch(3, 3, 8'h00);
        exp_vec(cyc + 2, '0, "R7 configured but asleep");

        wr(8'h00, 8'h00);
        w  = cyc;
        t0 = w + 2 + S;
        t1 = t0 + PER;
        t2 = t1 + PER;
        t3 = t2 + PER;
        exp_vec(w + S, '0, "R11 settle after wake");
        exp_bit(t0 + 19,  0, 1'b0, "R2 R3 before ON");
        exp_bit(t0 + 20,  0, 1'b1, "R2 R3 at ON");
        exp_bit(t0 + 60,  2, 1'b0, "R2 equal ON OFF");
        exp_bit(t0 + 60,  3, 1'b0, "R6 disabled channel");
        exp_bit(t0 + 99,  0, 1'b1, "R4 old OFF still high");
        exp_bit(t0 + 100, 0, 1'b0, "R4 old OFF kept in running period");
        exp_bit(t0 + 199, 1, 1'b0, "R2 wrap channel low");
        exp_bit(t0 + 200, 1, 1'b1, "R2 wrap channel rises");

        wait_to(t0 + 50);
        wr_ch(0, 2, 8'd200);                                      // R4 buffered update
        wait_to(t0 + 300);
        wr(8'h01, 8'd5);                                          // R9 ignored while running

        exp_bit(t1 + 19,  0, 1'b0, "R9 period unchanged");
        exp_bit(t1 + 20,  0, 1'b1, "R9 period unchanged");
        exp_bit(t1 + 39,  1, 1'b1, "R2 high across wrap");
        exp_bit(t1 + 40,  1, 1'b0, "R2 falls after wrap");
        exp_bit(t1 + 399, 0, 1'b1, "R4 new OFF next period");
        exp_bit(t1 + 400, 0, 1'b0, "R4 new OFF next period");

        wait_to(t1 + 500);
        wr(8'h00, 8'h04);                                         // acknowledge-update mode
        exp_bit(t2 + 19, 0, 1'b0, "R5 partial write ignored");
        exp_bit(t2 + 20, 0, 1'b1, "R5 partial write ignored");
        wait_to(t2 + 4);
        wr_ch(0, 0, 8'd40);
        xact();

        wait_to(t2 + 1000);
        wr_ch(0, 1, 8'h10); wr_ch(0, 2, 8'd128); wr_ch(0, 3, 8'h00);
        xact();
        exp_bit(t3 + 79,  0, 1'b0, "R5 full set applied");
        exp_bit(t3 + 80,  0, 1'b1, "R5 full set applied");
        exp_bit(t3 + 255, 0, 1'b1, "R5 full set applied");
        exp_bit(t3 + 256, 0, 1'b0, "R5 full set applied");

        wait_to(t3 + 300);
        wr(8'h00, 8'h06);
        wi = cyc;
        exp_vec(wi + 1, 4'b1101, "R8 invert set");
        wr(8'h00, 8'h04);
        wn = cyc;
        exp_vec(wn + 1, 4'b0010, "R8 invert cleared");
        exp_bit(t3 + 399, 1, 1'b1, "R7 running before sleep");

        wait_to(t3 + 400);
        wr(8'h00, 8'h05);                                         // sleep with channels on
        ws = cyc;
        exp_vec(ws + 2, '0, "R7 sleep forces inactive");
        exp_rp(ws + 2, 1'b0, "R10 no flag while asleep");
        wr(8'h01, 8'd0);                                          // R9 accepted asleep

        wr(8'h00, 8'h00);
        ww = cyc;
        exp_rp(ww + 2, 1'b1, "R10 parked after wake");
        exp_vec(ww + 300, '0, "R10 parked outputs inactive");
        wait_to(ww + 310);

        wr(8'h00, 8'h08);
        wr_c = cyc;
        t4   = wr_c + 2 + S;
        exp_rp(wr_c + 2, 1'b0, "R10 flag cleared by restart");
        exp_vec(wr_c + S, '0, "R11 settle after restart");
        exp_bit(t4 + 39,  0, 1'b0, "R10 R9 resumed at new prescale");
        exp_bit(t4 + 40,  0, 1'b1, "R10 R9 resumed at new prescale");
        exp_bit(t4 + 127, 0, 1'b1, "R10 resumed");
        exp_bit(t4 + 128, 0, 1'b0, "R10 resumed");

        wait_to(t4 + 200);
        finish_run();
    end

endmodule